// File: doc/BRIEF.md
# Key-Sequence Register Write Guard

This block sits between a host byte-write port and a group of configuration and time registers that must not change by accident. The guarded registers stay closed until the host writes two fixed key bytes, one after the other, to a dedicated key address. Any other byte at that address closes them again. The block does not hold the guarded registers. It passes on a gated, one-cycle write enable and the data byte to whichever of them the host addresses.

The time, date and prescaler registers need more than the unlock. The host must first request initialization mode through a control register. It must then wait for an acknowledge flag, which rises only after a fixed number of slow-clock ticks. When the request is withdrawn, the acknowledge falls after the same number of ticks. At that moment a "registers synchronized" flag is set. The alarm register needs only the unlock.

A write that the guard refuses never reaches a register. It sets a sticky error flag, which only reset clears.

Top module: `keyseq_wprot`

## Requirements
- R1: After reset, the block is locked, the init request and acknowledge are 0, the synchronized flag and error flag are 0, and no write enable is active.
- R2: Writing 0xCA to the key address (0) and then 0x53 to the key address opens the guard. `unlocked_o` is 1 in the cycle after the second write.
- R3: A first key byte other than 0xCA leaves the block locked. A byte other than 0x53 in the second position, including a repeated 0xCA, returns the sequence to the locked idle state. A new unlock must then begin with 0xCA.
- R4: In the cycle after the host writes any other byte to the key address, the block is locked again.
- R5: A write to any non-key address between the two key bytes abandons the sequence.
- R6: Bit 0 of a write to the control address (1) sets or clears the init request, but only while the block is unlocked. While locked, such writes are ignored. Relocking clears the request.
- R7: `init_ack_o` follows a change of the init request only at the edge of the SYNC_TICKS-th `slow_tick` cycle after that change (default 3). It rises after setting and falls after clearing.
- R8: `synced_o` clears when an init request is set. It sets at the same edge at which the acknowledge falls.
- R9: Writes to time (address 2), date (3) and prescaler (4) are accepted only while the block is unlocked and `init_ack_o` is 1. An accepted write drives `reg_we_o` bit 0, 1 or 2 respectively, with the byte on `reg_wdata_o`, in the cycle after the write.
- R10: A write to the alarm register (address 5) is accepted whenever the block is unlocked, without init mode. It drives `reg_we_o` bit 3.
- R11: A refused write to addresses 2 to 5 produces no write enable. It sets `wr_err_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_tick | input | 1 | One-cycle enable marking a slow-clock tick |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write byte |
| unlocked_o | output | 1 | Guard open |
| init_req_o | output | 1 | Init mode requested |
| init_ack_o | output | 1 | Init mode acknowledged |
| synced_o | output | 1 | Registers synchronized after leaving init |
| wr_err_o | output | 1 | Sticky refused-write flag |
| reg_we_o | output | 4 | Gated write enables: time, date, prescaler, alarm |
| reg_wdata_o | output | 8 | Byte for the enabled register |

## Verification
Every output is registered. The lock state, init request, write enables and error flag therefore change at the first clock edge after the host write. The bench applies each write for one cycle from a falling edge and samples at the next falling edge, where the result of that single edge is visible.

The acknowledge and synchronized flags depend on slow ticks, not on cycles. The bench pulses the tick one cycle at a time. It checks that the acknowledge is still unchanged after SYNC_TICKS-1 ticks and has changed after the SYNC_TICKS-th tick. Enable pulses last a single cycle, so they are checked in exactly that sampling slot.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned N_GUARD = 4;

    // address map; guarded registers are contiguous from A_TIME
    localparam logic [ADDR_W-1:0] A_KEY   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TIME  = 3'd2;

    // guarded registers that additionally need init mode (time, date, prescaler)
    localparam logic [N_GUARD-1:0] INIT_MASK = 4'b0111;

    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'hCA;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h53;

    typedef enum logic [1:0] {
        KS_LOCKED,
        KS_HALF,
        KS_OPEN
    } key_state_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } host_wr_t;

endpackage

// File: rtl/wprot_key_fsm.sv
module wprot_key_fsm
    import wprot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  host_wr_t wr,
    output logic     unlocked,
    output logic     relock
);

    typedef struct packed {
        key_state_e st;
    } key_regs_t;

    key_regs_t q, d;

    logic key_hit;
    logic other_hit;

    always_comb begin
        d         = q;
        key_hit   = wr.en && (wr.addr == A_KEY);
        other_hit = wr.en && (wr.addr != A_KEY);
        unique case (q.st)
            KS_LOCKED: begin
                if (key_hit && wr.data == KEY_FIRST) d.st = KS_HALF;
            end
            KS_HALF: begin
                if (key_hit) begin
                    d.st = (wr.data == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
                end else if (other_hit) begin
                    d.st = KS_LOCKED;
                end
            end
            KS_OPEN: begin
                if (key_hit) d.st = KS_LOCKED;
            end
            default: d.st = KS_LOCKED;
        endcase
        relock = (q.st == KS_OPEN) && (d.st != KS_OPEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: KS_LOCKED};
        else        q <= d;
    end

    assign unlocked = (q.st == KS_OPEN);

endmodule

// File: rtl/wprot_init_sync.sv
module wprot_init_sync #(
    parameter int unsigned SYNC_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    input  logic unlocked,
    input  logic relock,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic req,
    output logic ack,
    output logic synced
);

    localparam int unsigned CNT_W = (SYNC_TICKS < 2) ? 1 : $clog2(SYNC_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_TICKS - 1);

    typedef struct packed {
        logic             req;
        logic             ack;
        logic             synced;
        logic [CNT_W-1:0] cnt;
    } init_regs_t;

    init_regs_t q, d;

    always_comb begin
        d = q;
        // request register
        if (relock) begin
            d.req = 1'b0;
        end else if (ctrl_wr && unlocked) begin
            d.req = ctrl_bit;
            if (ctrl_bit && !q.req) d.synced = 1'b0;
        end
        // acknowledge follows the request after SYNC_TICKS ticks
        if (q.req != q.ack) begin
            if (slow_tick) begin
                if (q.cnt == CNT_LAST) begin
                    d.cnt = '0;
                    d.ack = q.req;
                    if (!q.req) d.synced = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req    = q.req;
    assign ack    = q.ack;
    assign synced = q.synced;

endmodule

// File: rtl/wprot_write_gate.sv
module wprot_write_gate
    import wprot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  host_wr_t           wr,
    input  logic               unlocked,
    input  logic               init_ack,
    output logic [N_GUARD-1:0] we,
    output logic [BYTE_W-1:0]  wdata,
    output logic               err
);

    typedef struct packed {
        logic [N_GUARD-1:0] we;
        logic [BYTE_W-1:0]  wdata;
        logic               err;
    } gate_regs_t;

    gate_regs_t q, d;

    logic [N_GUARD-1:0] hit;
    logic [N_GUARD-1:0] allow;

    for (genvar g = 0; g < N_GUARD; g++) begin : g_slot
        assign hit[g] = wr.en && (wr.addr == A_TIME + ADDR_W'(g));
        if (INIT_MASK[g]) begin : g_init
            assign allow[g] = unlocked && init_ack;
        end else begin : g_plain
            assign allow[g] = unlocked;
        end
    end

    always_comb begin
        d    = q;
        d.we = hit & allow;
        if (|(hit & allow)) d.wdata = wr.data;
        if (|(hit & ~allow)) d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign we    = q.we;
    assign wdata = q.wdata;
    assign err   = q.err;

endmodule

// File: rtl/keyseq_wprot.sv
module keyseq_wprot
    import wprot_pkg::*;
#(
    parameter int unsigned SYNC_TICKS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic               unlocked_o,
    output logic               init_req_o,
    output logic               init_ack_o,
    output logic               synced_o,
    output logic               wr_err_o,
    output logic [N_GUARD-1:0] reg_we_o,
    output logic [BYTE_W-1:0]  reg_wdata_o
);

    host_wr_t wr;
    logic     unlocked;
    logic     relock;
    logic     ack;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    wprot_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .unlocked (unlocked),
        .relock   (relock)
    );

    wprot_init_sync #(.SYNC_TICKS(SYNC_TICKS)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .unlocked  (unlocked),
        .relock    (relock),
        .ctrl_wr   (wr_en && (wr_addr == A_CTRL)),
        .ctrl_bit  (wr_data[0]),
        .req       (init_req_o),
        .ack       (ack),
        .synced    (synced_o)
    );

    wprot_write_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .unlocked (unlocked),
        .init_ack (ack),
        .we       (reg_we_o),
        .wdata    (reg_wdata_o),
        .err      (wr_err_o)
    );

    assign unlocked_o = unlocked;
    assign init_ack_o = ack;

endmodule

// File: rtl/keyseq_wprot_checker.sv
module keyseq_wprot_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       slow_tick,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       unlocked_o,
    input logic       init_ack_o,
    input logic       synced_o,
    input logic       wr_err_o,
    input logic [3:0] reg_we_o
);

    a_r2_open_only_on_second_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked_o) |-> $past(wr_en && wr_addr == 3'd0 && wr_data == 8'h53));

    a_r4_key_write_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked_o && wr_en && wr_addr == 3'd0) |=> !unlocked_o);

    a_r7_ack_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (init_ack_o != $past(init_ack_o)) |-> $past(slow_tick));

    a_r8_sync_with_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced_o) |-> $fell(init_ack_o));

    a_r9_init_writes_need_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_we_o[2:0]) |-> $past(init_ack_o && unlocked_o));

    a_r10_alarm_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o[3] |-> $past(unlocked_o));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |=> wr_err_o);

    a_r9_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we_o));

endmodule

bind keyseq_wprot keyseq_wprot_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_tick  (slow_tick),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .unlocked_o (unlocked_o),
    .init_ack_o (init_ack_o),
    .synced_o   (synced_o),
    .wr_err_o   (wr_err_o),
    .reg_we_o   (reg_we_o)
);

// File: tb/keyseq_wprot_test.sv
module keyseq_wprot_test;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       unlocked_o, init_req_o, init_ack_o, synced_o, wr_err_o;
    logic [3:0] reg_we_o;
    logic [7:0] reg_wdata_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    keyseq_wprot #(.SYNC_TICKS(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .unlocked_o(unlocked_o), .init_req_o(init_req_o), .init_ack_o(init_ack_o),
        .synced_o(synced_o), .wr_err_o(wr_err_o),
        .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; slow_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one-cycle write; returns at the falling edge where its result is visible
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    endtask

    task automatic unlock();
        wr(3'd0, 8'hCA);
        wr(3'd0, 8'h53);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 unlocked", unlocked_o, 0);
        chk("R1 init_req", init_req_o, 0);
        chk("R1 init_ack", init_ack_o, 0);
        chk("R1 synced", synced_o, 0);
        chk("R1 err", wr_err_o, 0);
        chk("R1 we", reg_we_o, 0);
    endtask

    task automatic t_unlock();
        do_reset();
        wr(3'd0, 8'hCA);
        chk("R2 half sequence still locked", unlocked_o, 0);
        wr(3'd0, 8'h53);
        chk("R2 open after both keys", unlocked_o, 1);
        wr(3'd0, 8'hFF);
        chk("R4 relock on other byte", unlocked_o, 0);
        unlock();
        wr(3'd0, 8'hCA);
        chk("R4 key byte at open relocks", unlocked_o, 0);
    endtask

    task automatic t_bad_keys();
        do_reset();
        wr(3'd0, 8'h53); wr(3'd0, 8'h53);
        chk("R3 wrong first key", unlocked_o, 0);
        wr(3'd0, 8'hCA); wr(3'd0, 8'hCA); wr(3'd0, 8'h53);
        chk("R3 repeated first key restarts", unlocked_o, 0);
        wr(3'd0, 8'hCA); wr(3'd0, 8'h12); wr(3'd0, 8'h53);
        chk("R3 wrong second key restarts", unlocked_o, 0);
        unlock();
        chk("R3 fresh sequence opens", unlocked_o, 1);
    endtask

    task automatic t_interleave();
        do_reset();
        wr(3'd0, 8'hCA); wr(3'd5, 8'h00); wr(3'd0, 8'h53);
        chk("R5 intervening write abandons", unlocked_o, 0);
    endtask

    task automatic t_locked();
        do_reset();
        wr(3'd1, 8'h01);
        chk("R6 init ignored while locked", init_req_o, 0);
        tick(SYNC);
        chk("R6 no ack while locked", init_ack_o, 0);
        wr(3'd5, 8'h77);
        chk("R11 locked alarm write no enable", reg_we_o, 0);
        chk("R11 locked write sets error", wr_err_o, 1);
        unlock();
        wr(3'd5, 8'h21);
        chk("R11 error stays sticky", wr_err_o, 1);
    endtask

    task automatic t_no_init();
        do_reset();
        unlock();
        wr(3'd2, 8'h11);
        chk("R9 time write without init dropped", reg_we_o, 0);
        chk("R11 dropped write flags error", wr_err_o, 1);
        do_reset();
        unlock();
        wr(3'd5, 8'h42);
        chk("R10 alarm enable", reg_we_o, 4'b1000);
        chk("R10 alarm data", reg_wdata_o, 8'h42);
        chk("R10 no error", wr_err_o, 0);
    endtask

    task automatic t_init_flow();
        do_reset();
        unlock();
        wr(3'd1, 8'h01);
        chk("R6 request set", init_req_o, 1);
        tick(SYNC - 1);
        chk("R7 ack not early", init_ack_o, 0);
        tick(1);
        chk("R7 ack after SYNC ticks", init_ack_o, 1);
        wr(3'd2, 8'h59);
        chk("R9 time enable", reg_we_o, 4'b0001);
        chk("R9 time data", reg_wdata_o, 8'h59);
        wr(3'd3, 8'h31);
        chk("R9 date enable", reg_we_o, 4'b0010);
        wr(3'd4, 8'h7F);
        chk("R9 prescaler enable", reg_we_o, 4'b0100);
        chk("R9 prescaler data", reg_wdata_o, 8'h7F);
        chk("R9 no error", wr_err_o, 0);
        wr(3'd1, 8'h00);
        chk("R6 request cleared", init_req_o, 0);
        tick(SYNC - 1);
        chk("R7 ack held before exit", init_ack_o, 1);
        chk("R8 not synced yet", synced_o, 0);
        tick(1);
        chk("R7 ack falls", init_ack_o, 0);
        chk("R8 synced with ack fall", synced_o, 1);
        wr(3'd1, 8'h01);
        chk("R8 synced clears on new request", synced_o, 0);
        wr(3'd0, 8'hFF);
        chk("R6 relock clears request", init_req_o, 0);
        chk("R4 relocked", unlocked_o, 0);
        wr(3'd5, 8'h09);
        chk("R11 alarm after relock dropped", reg_we_o, 0);
    endtask

    initial begin
        t_reset();
        t_unlock();
        t_bad_keys();
        t_interleave();
        t_locked();
        t_no_init();
        t_init_flow();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule